// File: doc/BRIEF.md
# I2C Byte-Level Slave Interface

This block is the slave side of a two-wire serial bus, built for a microcontroller-style peripheral. It samples the SCL and SDA bus lines through a two-stage synchronizer and pulls SDA low through an open-drain output. It detects START and STOP conditions and shifts in a 7-bit calling address with a direction bit. It compares that address against an own-address register that the host programs. When the address matches, the block acknowledges, raises a matched flag and records the direction.

Software reads the direction flag and then writes the role bit. With the role bit set the block transmits, and with it clear the block receives. Every data byte passes through one data register. As a receiver, the block drives the acknowledge level that the host has chosen. As a transmitter, it records the master's acknowledge. It goes on to the next byte only when that acknowledge is low. After a not-acknowledge it lets go of SDA and waits for a STOP. An event flag tells the host when an address has matched or a byte has finished.

The system clock must run at least 8 times faster than SCL. The bus master must change SDA only while SCL is low, except for START and STOP.

Top module: `i2c_byte_slave`

## Requirements
- R1: After reset, every host register reads 0x00 and `sda_pull` is 0. Host offset 0 is the own address (bits 6:0), offset 1 is control/status, offset 2 is data and offset 3 reads 0.
- R2: A STOP (SDA rising while SCL is high) or a repeated START (SDA falling while SCL is high) clears the matched flag (status bit 4) and returns the engine to idle or to address reception, with SDA released.
- R3: After the 8th SCL clock of an address byte, the block pulls SDA low for the 9th clock only if the first 7 bits, MSB first, equal the own address. It then sets the matched flag. A mismatch causes no drive and no flag.
- R4: On a match, status bit 5 takes the 8th address bit: 1 means the master reads (the slave transmits), 0 means the master writes (the slave receives).
- R5: As a receiver (control bit 0 = 0), the block shifts 8 bits MSB first into the data register. On the 9th clock it pulls SDA low when control bit 1 is 0 and leaves SDA released when control bit 1 is 1.
- R6: As a transmitter (control bit 0 = 1, read at the end of the address acknowledge clock), the block sends the data register MSB first, one bit per SCL clock, changing SDA only after a falling SCL edge.
- R7: As a transmitter, the block samples SDA on the 9th clock into status bit 6. A low value loads and sends the data register as the next byte. A high value releases SDA until a START or STOP.
- R8: `sda_pull` changes only while SCL is low.
- R9: Status bit 7 is set on each address match, each received byte and each sampled transmit acknowledge. Any host write to offset 1 clears it, and a new event in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen on the pad |
| sda_in | input | 1 | Bus data line as seen on the pad |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 2 | Host register offset |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational) |

## Verification
The bench builds the block with the default two-stage synchronizer. It clocks the bus at 40 system clocks per SCL period, which leaves room for the host to program the role and acknowledge bits between address phases. It covers these cases: a matched write with an acknowledged byte and a not-acknowledged byte, a mismatched address, a matched read whose two bytes end in a master NACK, and a repeated START in the middle of a transfer. On every clock it checks that the open-drain drive never moves while the bench holds SCL high.

// File: rtl/i2c_byte_slave.sv
module i2c_byte_slave #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_pull,
  input  logic       host_we,
  input  logic [1:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata
);
  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_RX, S_RACK, S_TX, S_TACK, S_WAIT} st_t;

  st_t st;
  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q;
  logic [6:0] own_addr;
  logic tx_mode, txak_bit, matched, rw_bit, rxak, pend;
  logic [7:0] data_r, sh;
  logic [3:0] cnt;

  wire scl_s = scl_sh[SYNC_STAGES-1];
  wire sda_s = sda_sh[SYNC_STAGES-1];
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_c = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c  = scl_s & scl_q & ~sda_q & sda_s;
  wire ctl_wr  = host_we && host_addr == 2'd1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_in};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_in};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE;
      own_addr <= '0;
      tx_mode <= 1'b0;
      txak_bit <= 1'b0;
      matched <= 1'b0;
      rw_bit <= 1'b0;
      rxak <= 1'b0;
      pend <= 1'b0;
      data_r <= '0;
      sh <= '0;
      cnt <= '0;
      sda_pull <= 1'b0;
    end else begin
      if (host_we && host_addr == 2'd0) own_addr <= host_wdata[6:0];
      if (ctl_wr) begin
        tx_mode <= host_wdata[0];
        txak_bit <= host_wdata[1];
        pend <= 1'b0;
      end
      if (host_we && host_addr == 2'd2) data_r <= host_wdata;

      if (start_c) begin
        st <= S_ADDR;
        cnt <= '0;
        matched <= 1'b0;
        sda_pull <= 1'b0;
      end else if (stop_c) begin
        st <= S_IDLE;
        matched <= 1'b0;
        sda_pull <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_RX:
            if (scl_rise) begin
              sh <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (st == S_ADDR) begin
                if (sh[7:1] == own_addr) begin
                  st <= S_AACK;
                  sda_pull <= 1'b1;
                  matched <= 1'b1;
                  rw_bit <= sh[0];
                  pend <= 1'b1;
                end else begin
                  st <= S_WAIT;
                end
              end else begin
                data_r <= sh;
                pend <= 1'b1;
                st <= S_RACK;
                sda_pull <= ~txak_bit;
              end
            end
          S_AACK, S_RACK:
            if (scl_fall) begin
              cnt <= '0;
              if (st == S_AACK && tx_mode) begin
                st <= S_TX;
                sh <= data_r;
                sda_pull <= ~data_r[7];
              end else begin
                st <= S_RX;
                sda_pull <= 1'b0;
              end
            end
          S_TX:
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall) begin
              if (cnt == 4'd8) begin
                st <= S_TACK;
                sda_pull <= 1'b0;
              end else begin
                sh <= {sh[6:0], 1'b0};
                sda_pull <= ~sh[6];
              end
            end
          S_TACK:
            if (scl_rise) begin
              rxak <= sda_s;
              pend <= 1'b1;
            end else if (scl_fall) begin
              cnt <= '0;
              if (!rxak) begin
                st <= S_TX;
                sh <= data_r;
                sda_pull <= ~data_r[7];
              end else begin
                st <= S_WAIT;
              end
            end
          default: ;
        endcase
      end
    end

  always_comb
    case (host_addr)
      2'd0: host_rdata = {1'b0, own_addr};
      2'd1: host_rdata = {pend, rxak, rw_bit, matched, 2'b00, txak_bit, tx_mode};
      2'd2: host_rdata = data_r;
      default: host_rdata = 8'h00;
    endcase

  a_r8_pull_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !$past(scl_s));
  a_r2_stop_clears_match: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> (!matched && st == S_IDLE && !sda_pull));
  a_r3_ack_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_AACK) |-> (matched && sda_pull));
  a_r7_nack_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT) |-> !sda_pull);
  a_r5_ack_level: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RACK && $past(st) == S_RX) |-> (sda_pull == !$past(txak_bit)));
endmodule

// File: tb/i2c_byte_slave_test.sv
module i2c_byte_slave_test;
  localparam int Q = 10;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, host_we = 1'b0;
  logic [1:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic sda_pull;
  wire sda_line = sda_m & ~sda_pull;
  int vecs = 0, bad = 0;
  bit done = 1'b0;
  logic scl_prev = 1'b1, pull_prev = 1'b0;

  i2c_byte_slave uut (.clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .sda_pull(sda_pull), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // R8 model: drive may not move while the bench holds SCL high
  always @(negedge clk) begin
    if (rst_n && !done) begin
      vecs++;
      if (scl_prev && scl_m && pull_prev !== sda_pull) begin
        bad++;
        $display("FAIL R8: actual pull %0b expected %0b with SCL high", sda_pull, pull_prev);
      end
    end
    scl_prev <= scl_m;
    pull_prev <= sda_pull;
  end

  function automatic logic [7:0] stat(input bit p, input bit rx, input bit rw, input bit m,
                                      input bit ak, input bit tx);
    return {p, rx, rw, m, 2'b00, ak, tx};
  endfunction

  task automatic qw; repeat (Q) @(negedge clk); endtask
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_we = 1'b0;
  endtask
  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); host_addr = a; #1 d = host_rdata;
  endtask
  task automatic start; sda_m = 1; scl_m = 1; qw; sda_m = 0; qw; scl_m = 0; qw; endtask
  task automatic rstart; sda_m = 1; qw; scl_m = 1; qw; sda_m = 0; qw; scl_m = 0; qw; endtask
  task automatic stop; sda_m = 0; qw; scl_m = 1; qw; sda_m = 1; qw; endtask
  task automatic bitx(input logic b, output logic got);
    sda_m = b; qw; scl_m = 1; qw; got = sda_line; qw; scl_m = 0; qw;
  endtask
  task automatic bytex(input logic [7:0] d, output logic [7:0] got);
    for (int i = 7; i >= 0; i--) begin
      logic g;
      bitx(d[i], g);
      got[i] = g;
    end
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1; vecs++; bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary;
    end
  end

  initial begin
    logic [7:0] r, g;
    logic a;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state and register map
    for (int k = 0; k < 4; k++) begin
      rd(k[1:0], r);
      chk("R1 reg", r, 8'h00);
    end
    chk("R1 pull", sda_pull, 1'b0);
    wr(2'd0, 8'h5A);
    rd(2'd0, r); chk("R1 own addr", r, 8'h5A);

    // matched write transfer
    start;
    bytex(8'hB4, g);
    rd(2'd1, r); chk("R3 R4 R9 match write", r, stat(1, 0, 0, 1, 0, 0));
    wr(2'd1, 8'h00);
    rd(2'd1, r); chk("R9 host clear", r, stat(0, 0, 0, 1, 0, 0));
    bitx(1'b1, a); chk("R3 address ack", a, 1'b0);
    bytex(8'hC3, g);
    bitx(1'b1, a); chk("R5 ack low", a, 1'b0);
    rd(2'd2, r); chk("R5 data MSB first", r, 8'hC3);
    rd(2'd1, r); chk("R9 byte event", r, stat(1, 0, 0, 1, 0, 0));
    wr(2'd1, 8'h02);
    bytex(8'h3C, g);
    bitx(1'b1, a); chk("R5 nack released", a, 1'b1);
    rd(2'd2, r); chk("R5 second byte", r, 8'h3C);
    stop;
    rd(2'd1, r); chk("R2 stop clears match", r[4], 1'b0);

    // mismatched address
    wr(2'd1, 8'h00);
    start;
    bytex(8'h44, g);
    bitx(1'b1, a); chk("R3 mismatch no ack", a, 1'b1);
    rd(2'd1, r); chk("R3 mismatch no flags", r, 8'h00);
    bytex(8'h00, g);
    bitx(1'b1, a); chk("R3 mismatch stays quiet", a, 1'b1);
    stop;

    // matched read transfer
    start;
    bytex(8'hB5, g);
    rd(2'd1, r); chk("R4 read direction", r, stat(1, 0, 1, 1, 0, 0));
    wr(2'd1, 8'h01);
    wr(2'd2, 8'hA5);
    bitx(1'b1, a); chk("R3 read ack", a, 1'b0);
    bytex(8'hFF, g); chk("R6 first byte", g, 8'hA5);
    wr(2'd2, 8'h69);
    bitx(1'b0, a);
    rd(2'd1, r); chk("R7 R9 ack sampled", r, stat(1, 0, 1, 1, 0, 1));
    bytex(8'hFF, g); chk("R7 next byte loaded", g, 8'h69);
    bitx(1'b1, a);
    rd(2'd1, r); chk("R7 nack sampled", r[6], 1'b1);
    bytex(8'hFF, g); chk("R7 released after nack", g, 8'hFF);
    chk("R7 pull idle", sda_pull, 1'b0);
    stop;

    // repeated start mid-transfer
    wr(2'd1, 8'h00);
    start;
    bytex(8'hB4, g);
    bitx(1'b1, a); chk("R3 ack before restart", a, 1'b0);
    rstart;
    rd(2'd1, r); chk("R2 restart clears match", r[4], 1'b0);
    bytex(8'hB5, g);
    rd(2'd1, r); chk("R2 R4 rematch after restart", r[5:4], 2'b11);
    bitx(1'b1, a); chk("R3 ack after restart", a, 1'b0);
    stop;
    rd(2'd1, r); chk("R2 final stop", r[4], 1'b0);

    done = 1'b1;
    summary;
  end
endmodule